// File: doc/BRIEF.md
# Serial Stereo Audio Receiver with Word-Length Inference

This block takes a two-wire-plus-data stereo audio stream in I2S framing (bit clock, word-select, serial data) and turns it into parallel samples inside a faster system clock domain. All three external lines pass through a synchroniser, and the rising edges of the bit clock are found in the system domain. At each such edge the data line is taken as one bit slot of the current half-frame.

Each half-frame is delivered as a 24-bit word, MSB-aligned, together with a one-cycle strobe for its channel. The sample width carried by the source (16 to 24 bits) is not configured. The block deduces it from the position of the last active bit in each frame and publishes the result as a 5-bit value. That value only moves once two frames in a row agree.

Top module: `i2s_wordlen_rx`

## Requirements
- R1: After reset both data outputs are zero, both strobes are low and the word length output reads 24.
- R2: The bit sampled on the first bit-clock rising edge after a word-select change is the MSB of the new half-frame. The bit sampled on the edge that first shows the new word-select level is the final slot of the old half-frame.
- R3: Word-select low selects the left channel and high selects the right channel. Each completed half-frame raises exactly its own channel strobe for one system clock cycle, and the two strobes are never high together.
- R4: Slot k of a half-frame (k = 1 for the MSB, up to 24) lands on output bit 24-k. Output bits for slots a half-frame did not carry read zero, so a shorter word comes out left-justified.
- R5: Slots 25 and later of a half-frame change neither the data outputs nor the word length.
- R6: The candidate length of a frame (a left half-frame followed by a right half-frame) is the highest slot number, from 1 to 24, that carries a 1 in either half. A candidate below 16 is raised to 16.
- R7: The word length output is 5 bits wide and always lies between 16 and 24. It takes a new value only at a right-channel strobe, and only when the candidates of that frame and of the frame before it are equal.
- R8: Bits received before the first word-select change after reset form no sample, and no strobe is raised for them.
- R9: Each data output keeps its value between strobes of its own channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | External bit clock |
| ws | input | 1 | External word-select, low for left |
| sd | input | 1 | External serial data, MSB first |
| left_data | output | 24 | Last left sample, MSB-aligned |
| left_valid | output | 1 | One-cycle strobe for a new left sample |
| right_data | output | 24 | Last right sample, MSB-aligned |
| right_valid | output | 1 | One-cycle strobe for a new right sample |
| word_len | output | 5 | Confirmed sample width in bits |

## Verification
The right-channel strobe and the word-length update fall on the same clock edge, because completing the right half-frame is what closes a frame. The bench sweeps every width from 16 to 24 with three frames each, so that both functions are exercised on that shared edge. At the first frame of each new width, the right sample must already be the new one while the length still shows the previous width. From the second frame on, both must show the new width. Junk bits past slot 24, all-zero frames and a half-frame cut short at 20 slots confirm that the same edge never takes up stray bits.

// File: rtl/i2s_wordlen_rx.sv
module i2s_wordlen_rx #(
  parameter int SYNC    = 2,
  parameter int OUT_W   = 24,
  parameter int MIN_LEN = 16,
  parameter int LEN_W   = 5,
  parameter int CNT_W   = 6
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sck,
  input  logic             ws,
  input  logic             sd,
  output logic [OUT_W-1:0] left_data,
  output logic             left_valid,
  output logic [OUT_W-1:0] right_data,
  output logic             right_valid,
  output logic [LEN_W-1:0] word_len
);
  localparam int IW = $clog2(OUT_W);

  logic [2:0] sync_q [SYNC];
  logic       sck_last;
  logic       seen, armed, ws_prev, left_got, have_last;
  logic [CNT_W-1:0] cnt;
  logic [OUT_W-1:0] sh, nxt_sh;
  logic [LEN_W-1:0] hi, nxt_hi, left_hi, last_cand, top, cand;

  wire sck_s  = sync_q[SYNC-1][2];
  wire ws_s   = sync_q[SYNC-1][1];
  wire sd_s   = sync_q[SYNC-1][0];
  wire rise   = sck_s & ~sck_last;
  wire ws_chg = ws_s ^ ws_prev;
  wire in_word = cnt < CNT_W'(OUT_W);
  wire [IW-1:0] pos = IW'(OUT_W - 1) - IW'(cnt);

  always_comb begin
    nxt_sh = sh;
    if (in_word) nxt_sh[pos] = sd_s;
  end

  assign nxt_hi = (in_word && sd_s) ? LEN_W'(cnt) + 1'b1 : hi;
  assign top    = (left_hi > nxt_hi) ? left_hi : nxt_hi;
  assign cand   = (top < LEN_W'(MIN_LEN)) ? LEN_W'(MIN_LEN) : top;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC; i++) sync_q[i] <= '0;
      sck_last <= 1'b0;
    end else begin
      sync_q[0] <= {sck, ws, sd};
      for (int i = 1; i < SYNC; i++) sync_q[i] <= sync_q[i-1];
      sck_last <= sck_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen        <= 1'b0;
      armed       <= 1'b0;
      ws_prev     <= 1'b0;
      left_got    <= 1'b0;
      have_last   <= 1'b0;
      cnt         <= '0;
      sh          <= '0;
      hi          <= '0;
      left_hi     <= '0;
      last_cand   <= '0;
      left_data   <= '0;
      right_data  <= '0;
      left_valid  <= 1'b0;
      right_valid <= 1'b0;
      word_len    <= LEN_W'(OUT_W);
    end else begin
      left_valid  <= 1'b0;
      right_valid <= 1'b0;
      if (rise) begin
        seen    <= 1'b1;
        ws_prev <= ws_s;
        if (!armed) begin
          if (seen && ws_chg) armed <= 1'b1;
          cnt <= '0;
          sh  <= '0;
          hi  <= '0;
        end else if (ws_chg) begin
          cnt <= '0;
          sh  <= '0;
          hi  <= '0;
          if (!ws_prev) begin
            left_data  <= nxt_sh;
            left_valid <= 1'b1;
            left_hi    <= nxt_hi;
            left_got   <= 1'b1;
          end else begin
            right_data  <= nxt_sh;
            right_valid <= 1'b1;
            if (left_got) begin
              left_got  <= 1'b0;
              have_last <= 1'b1;
              last_cand <= cand;
              if (have_last && last_cand == cand) word_len <= cand;
            end
          end
        end else begin
          if (cnt != '1) cnt <= cnt + 1'b1;
          sh <= nxt_sh;
          hi <= nxt_hi;
        end
      end
    end
  end

  p_len_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    word_len >= LEN_W'(MIN_LEN) && word_len <= LEN_W'(OUT_W));
  p_len_at_right_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(word_len) |-> right_valid);
  p_one_channel_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(left_valid && right_valid));
  p_left_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    left_valid |=> !left_valid);
  p_right_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    right_valid |=> !right_valid);
  p_hold_left_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(left_data) |-> left_valid);
  p_hold_right_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(right_data) |-> right_valid);
  p_no_early_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (left_valid || right_valid) |-> armed);
endmodule

// File: tb/tb_i2s_wordlen_rx.sv
module tb_i2s_wordlen_rx;
  logic clk = 1'b0, rst_n = 1'b0, sck_i = 1'b0, ws_i = 1'b0, sd_i = 1'b0;
  logic [23:0] left_data, right_data;
  logic left_valid, right_valid;
  logic [4:0] word_len;
  int checks = 0, errors = 0, nl = 0, nr = 0;
  logic [23:0] gl = '0, gr = '0;
  bit done = 0;

  always #2 clk = ~clk;

  i2s_wordlen_rx dut (.clk(clk), .rst_n(rst_n), .sck(sck_i), .ws(ws_i), .sd(sd_i),
    .left_data(left_data), .left_valid(left_valid), .right_data(right_data),
    .right_valid(right_valid), .word_len(word_len));

  always @(negedge clk) begin
    if (left_valid)  begin nl++; gl = left_data;  end
    if (right_valid) begin nr++; gr = right_data; end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bitp(input logic w, input logic d);
    @(negedge clk); sck_i = 1'b0; ws_i = w; sd_i = d;
    repeat (4) @(negedge clk);
    sck_i = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic send_half(input logic c, input logic [31:0] s, input int n);
    for (int i = 1; i <= n; i++) bitp((i == n) ? ~c : c, s[32-i]);
  endtask

  function automatic logic [31:0] mk(input logic [23:0] v, input int len, input bit junk);
    logic [31:0] s;
    s = {8'h00, v & ((24'h1 << len) - 24'h1)} << (32 - len);
    if (junk) s[7:0] = 8'hFF;
    return s;
  endfunction

  function automatic logic [23:0] ex(input logic [23:0] v, input int len);
    return (v & ((24'h1 << len) - 24'h1)) << (24 - len);
  endfunction

  task automatic frame(input logic [23:0] lv, input logic [23:0] rv, input int len, input bit junk);
    nl = 0; nr = 0;
    send_half(1'b0, mk(lv, len, junk), 32);
    send_half(1'b1, mk(rv, len, junk), 32);
    @(negedge clk); sck_i = 1'b0;
    repeat (8) @(negedge clk);
    chk(nl == 1 && nr == 1, "R3 one strobe per channel", nl * 16 + nr, 17);
    chk(gl == ex(lv, len), junk ? "R5 left data with junk" : "R4 left data", gl, ex(lv, len));
    chk(gr == ex(rv, len), junk ? "R5 right data with junk" : "R4 right data", gr, ex(rv, len));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int prev;
    logic [23:0] lv, rv;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(left_data == 0 && right_data == 0, "R1 data zero", left_data ^ right_data, 0);
    chk(!left_valid && !right_valid, "R1 strobes low", {left_valid, right_valid}, 0);
    chk(word_len == 24, "R1 word length", word_len, 24);

    nl = 0; nr = 0;
    send_half(1'b1, 32'hFFFF_FFFF, 6);
    @(negedge clk); sck_i = 1'b0;
    repeat (8) @(negedge clk);
    chk(nl == 0 && nr == 0, "R8 no strobe before first change", nl + nr, 0);
    chk(left_data == 0 && right_data == 0, "R9 data held", left_data | right_data, 0);

    prev = 24;
    for (int len = 16; len <= 24; len++) begin
      for (int k = 0; k < 3; k++) begin
        lv = (24'h5A3C91 ^ 24'(len * 24'h1357 + k * 24'h0F0F)) | 24'h1;
        rv = 24'hC3A5E7 ^ 24'(len * 24'h2468 + k);
        frame(lv, rv, len, k == 1);
        if (k == 0) chk(word_len == prev, "R7 first frame keeps length", word_len, prev);
        else        chk(word_len == len, "R7 length after agreement", word_len, len);
      end
      prev = len;
    end

    frame(24'h0, 24'h0, 24, 1'b0);
    chk(word_len == 24, "R7 single zero frame keeps length", word_len, 24);
    frame(24'h0, 24'h0, 24, 1'b1);
    chk(word_len == 16, "R6 zero frames clamp to 16", word_len, 16);
    frame(24'h1, 24'h0, 10, 1'b0);
    frame(24'h1, 24'h0, 10, 1'b0);
    chk(word_len == 16, "R6 short candidate clamps to 16", word_len, 16);
    frame(24'h0, 24'h1, 21, 1'b1);
    frame(24'h0, 24'h3, 21, 1'b0);
    chk(word_len == 21, "R6 right half sets candidate", word_len, 21);

    nl = 0;
    send_half(1'b0, {24'hABCDFF, 8'h00}, 20);
    send_half(1'b1, 32'h0, 32);
    @(negedge clk); sck_i = 1'b0;
    repeat (8) @(negedge clk);
    chk(nl == 1, "R3 short half-frame strobe", nl, 1);
    chk(gl == 24'hABCDF0, "R2 transition-edge bit kept, R4 zero fill", gl, 24'hABCDF0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule